// File: doc/BRIEF.md
# Zero-Compacting Lane Register

The block takes a parallel word of eight 8-bit lanes and, on a load strobe, registers a packed copy of it. In the packed copy every non-zero lane comes first, in the order it had in the input, and the lanes that are left over are filled with zero. The whole packing is done by combinational logic in one clock. The result appears at the outputs on the edge that samples the strobe.

Each output lane has its own selector. The selector finds the input lane that holds the k-th non-zero value and steers it through a multiplexer. Output lane k can only be fed from input lanes k and above, so the multiplexer behind each output gets narrower as k rises. The last output lane reads only the last input lane. With the packed word the block also registers how many lanes were non-zero, and it raises a one-cycle valid pulse.

Top module: `zeroCompactor`

## Requirements
- R1: While reset is asserted (rstN low) and after it is released, every output lane, the count and the valid flag are zero until the first load.
- R2: Input lane i is bits [8*i+7:8*i] of dataIn, and output lane k is bits [8*k+7:8*k] of dataOut. On a clock edge where loadIn is high, the block registers the non-zero input lanes into output lanes 0, 1, 2 and so on, in ascending order of their input index.
- R3: On that same edge, every output lane above the last one filled with a non-zero value is loaded with zero.
- R4: On that same edge, nonZeroCount is loaded with the number of non-zero input lanes, a value from 0 to 8.
- R5: validOut is high for exactly the cycle after each edge that samples loadIn high, and low after any edge that samples loadIn low.
- R6: On an edge where loadIn is low, dataOut and nonZeroCount keep their values, whatever dataIn holds.
- R7: When all eight input lanes are non-zero, a load copies the input unchanged and the count is 8.
- R8: When all input lanes are zero, a load gives all-zero output lanes and a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadIn | input | 1 | Strobe that loads the packed result |
| dataIn | input | 64 | Eight 8-bit input lanes, lane 0 in the low bits |
| dataOut | output | 64 | Eight packed 8-bit output lanes |
| nonZeroCount | output | 4 | Number of non-zero lanes in the last loaded word |
| validOut | output | 1 | High for the cycle after a load |

## Verification
The packed lanes, the count and the valid pulse all change on the edge that samples loadIn high. There is no register between the input and that edge, so each result is due one edge after the stimulus is applied. The bench drives its inputs at the falling edge and updates its reference model at the next rising edge. It then compares every output one time unit later. Cycles with loadIn low are checked in the same way and must show the previous values unchanged, so the hold behaviour is tested on every idle clock as well as on every load.

// File: rtl/compact_pkg.sv
package compact_pkg;
  typedef struct packed {
    logic capture;
    logic publish;
  } ctrlStrobes_t;
endpackage

// File: rtl/compactCtrl.sv
module compactCtrl
  import compact_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadIn,
  output ctrlStrobes_t strobes,
  output logic         validOut
);
  always_comb begin
    strobes.capture = loadIn;
    strobes.publish = loadIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= strobes.publish;
  end

  p_valid_after_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadIn |=> validOut);
  p_valid_low_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !loadIn |=> !validOut);
endmodule

// File: rtl/compactDatapath.sv
module compactDatapath
  import compact_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int BUS_W = LANES * WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [BUS_W-1:0] dataIn,
  output logic [BUS_W-1:0] dataOut,
  output logic [CNT_W-1:0] nonZeroCount
);
  logic [LANES-1:0] laneNz;
  logic [CNT_W-1:0] rank [LANES];
  logic [CNT_W-1:0] total;
  logic [LANES-1:0] pick [LANES];
  logic [BUS_W-1:0] packedNext;

  // flag each non-zero input lane
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_nz
      assign laneNz[g] = |dataIn[g*WIDTH +: WIDTH];
    end
  endgenerate

  // rank[j]: how many non-zero lanes sit below lane j
  always_comb begin
    rank[0] = '0;
    for (int j = 1; j < LANES; j++)
      rank[j] = rank[j-1] + CNT_W'(laneNz[j-1]);
    total = rank[LANES-1] + CNT_W'(laneNz[LANES-1]);
  end

  // per-output selector, candidates limited to lanes k..LANES-1
  genvar k, j;
  generate
    for (k = 0; k < LANES; k++) begin : g_out
      for (j = 0; j < LANES; j++) begin : g_cand
        if (j >= k) begin : g_live
          assign pick[k][j] = laneNz[j] && (rank[j] == CNT_W'(k));
        end else begin : g_dead
          assign pick[k][j] = 1'b0;
        end
      end
      if (k == LANES - 1) begin : g_last
        assign packedNext[k*WIDTH +: WIDTH] =
          {WIDTH{pick[k][k]}} & dataIn[k*WIDTH +: WIDTH];
      end else begin : g_mux
        logic [WIDTH-1:0] acc;
        always_comb begin
          acc = '0;
          for (int c = k; c < LANES; c++)
            acc = acc | ({WIDTH{pick[k][c]}} & dataIn[c*WIDTH +: WIDTH]);
        end
        assign packedNext[k*WIDTH +: WIDTH] = acc;
      end
      p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(pick[k]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut      <= '0;
      nonZeroCount <= '0;
    end else if (strobes.capture) begin
      dataOut      <= packedNext;
      nonZeroCount <= total;
    end
  end

  // checks on the registered result
  logic [LANES-1:0] outNz;
  generate
    for (g = 0; g < LANES; g++) begin : g_onz
      assign outNz[g] = |dataOut[g*WIDTH +: WIDTH];
    end
    for (g = 0; g < LANES - 1; g++) begin : g_tail
      p_zero_tail_r3: assert property (@(posedge clk) disable iff (!rstN)
        !outNz[g] |-> !outNz[g+1]);
    end
  endgenerate

  p_count_matches_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outNz) == int'(nonZeroCount));
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(nonZeroCount) <= LANES);
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(dataOut) && $stable(nonZeroCount)));
endmodule

// File: rtl/zeroCompactor.sv
module zeroCompactor
  import compact_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int BUS_W = LANES * WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadIn,
  input  logic [BUS_W-1:0] dataIn,
  output logic [BUS_W-1:0] dataOut,
  output logic [CNT_W-1:0] nonZeroCount,
  output logic             validOut
);
  ctrlStrobes_t strobes;

  compactCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadIn   (loadIn),
    .strobes  (strobes),
    .validOut (validOut)
  );

  compactDatapath #(.LANES(LANES), .WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .dataIn       (dataIn),
    .dataOut      (dataOut),
    .nonZeroCount (nonZeroCount)
  );
endmodule

// File: tb/zeroCompactor_tb.sv
`timescale 1ns/1ps
module zeroCompactor_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadIn = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] dataOut;
  logic [3:0]  nonZeroCount;
  logic        validOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] expOut = '0;
  int          expCnt = 0;
  bit          expValid = 0;

  always #2.5 clk = ~clk;

  zeroCompactor u_dut (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .dataIn(dataIn),
    .dataOut(dataOut), .nonZeroCount(nonZeroCount), .validOut(validOut)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    for (int k = 0; k < 8; k++) begin
      byte unsigned e = expOut[k*8 +: 8];
      check(e != 0 ? {tag, "/R2 lane"} : {tag, "/R3 lane"},
            longint'(dataOut[k*8 +: 8]), longint'(e));
    end
    check({tag, "/R4 count"}, longint'(nonZeroCount), longint'(expCnt));
    check({tag, "/R5 valid"}, longint'(validOut), longint'(expValid));
  endtask

  // behavioural reference: filter non-zero bytes into a queue
  task automatic step(input bit ld, input logic [63:0] d, input string tag);
    byte unsigned q[$];
    @(negedge clk);
    loadIn = ld;
    dataIn = d;
    @(posedge clk);
    expValid = ld;
    if (ld) begin
      q = {};
      for (int i = 0; i < 8; i++)
        if (d[i*8 +: 8] != 0) q.push_back(d[i*8 +: 8]);
      expCnt = q.size();
      expOut = '0;
      for (int k = 0; k < q.size(); k++) expOut[k*8 +: 8] = q[k];
    end
    #1;
    compareAll(tag);
  endtask

  function automatic logic [63:0] pack8(input byte unsigned b0, b1, b2, b3,
                                         b4, b5, b6, b7);
    return {b7, b6, b5, b4, b3, b2, b1, b0};
  endfunction

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    #1;
    compareAll("R1 in reset");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    compareAll("R1 after release");
    step(0, 64'hFFEE_DDCC_BBAA_9988, "R1 idle before load");
    // spread example: 0,4,0,0,5,0,2,0 -> 4,5,2,0,...
    step(1, pack8(0, 4, 0, 0, 5, 0, 2, 0), "R2 example");
    step(0, pack8(9, 9, 9, 9, 9, 9, 9, 9), "R6 hold");
    step(0, '0, "R6 hold zero input");
    step(1, pack8(1, 2, 3, 4, 5, 6, 7, 8), "R7 all nonzero");
    step(1, '0, "R8 all zero");
    step(1, pack8(0, 0, 0, 0, 0, 0, 0, 8'h80), "R2 only top");
    step(1, pack8(8'hFF, 0, 0, 0, 0, 0, 0, 0), "R3 only bottom");
    step(1, pack8(0, 1, 0, 1, 0, 1, 0, 1), "R2 alternating");
    step(1, pack8(3, 3, 0, 0, 0, 0, 7, 7), "R3 gap");
    step(0, '1, "R5 idle after burst");
    for (int n = 0; n < 400; n++) begin
      logic [63:0] d;
      for (int i = 0; i < 8; i++)
        d[i*8 +: 8] = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
      step($urandom_range(0, 3) != 0, d, "R2 random");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule